// File: doc/BRIEF.md
# Thirty-two source interrupt controller

The block collects up to 32 interrupt request lines and turns them into two processor request outputs: an urgent (critical) request and a normal (non-critical) request. Each line is first conditioned by a per-line polarity choice (active high or active low) and a per-line sensitivity choice (level or edge). A conditioned request is captured in a status register, which software clears by writing ones to the bits it wants to drop. An enable register masks captured requests before they reach the outputs. A routing register sends each enabled request either to the critical output or to the non-critical output.

Alongside the two request outputs, the block presents a vector number for the single most urgent pending, enabled source, together with a valid flag. The vector is a programmable base plus the index of the winning source. One configuration bit picks the ranking: either line 0 wins or line 31 wins. Software reaches all configuration through a flat register port. That port has a write strobe, a 3-bit address, write data and a combinational read-data path. The block has no internal state machine. Every register updates on the clock edge at which it is written, and every output is combinational from the registers.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, status, enable and routing read 0, trigger reads 0 (all level), polarity reads all ones (all active high), and the vector configuration reads 0x00000001. Both request outputs are low, the valid flag is low and the vector is 0.
- R2: Register addresses are 0 status, 1 enable, 2 routing, 3 polarity, 4 trigger and 5 vector configuration. Enable, routing, polarity and trigger read back the last 32-bit value written to them. In the vector configuration register, bit 0 is the ranking bit and bits 15:8 are the base; every other bit reads 0. Addresses 6 and 7 read 0.
- R3: When a polarity bit is 1, its line is active when the line is high. When the polarity bit is 0, the line is active when it is low.
- R4: A trigger bit of 0 selects level mode. In level mode the status bit is set at the first clock edge at which the line is active. Writing a 1 to that status bit has no effect while the line stays active. Once the line is inactive, writing a 1 clears the bit.
- R5: A trigger bit of 1 selects edge mode. In edge mode the status bit is set only at a clock edge at which the line has just become active. It stays set after the line returns to inactive. Holding the line active does not set the bit again after it has been cleared. Writing 0 to a status bit never changes it.
- R6: Writing to the status register clears every bit written as 1 and only those bits. If a new edge arrives on a bit at the same clock edge as a clear of that bit, the bit stays set.
- R7: A source is pending when its status bit and its enable bit are both 1. A status bit is captured whatever its enable bit holds. A source whose enable bit is 0 raises neither request output and does not take part in the vector choice.
- R8: A pending source raises irq_crit when its routing bit is 1 and raises irq_ncrit when its routing bit is 0.
- R9: When the ranking bit is 1, the lowest-numbered pending source wins. irq_vec then equals the base plus the winning index.
- R10: When the ranking bit is 0, the highest-numbered pending source wins.
- R11: irq_vec_valid is high exactly when at least one source is pending. When it is low, irq_vec is 0.
- R12: The sum of the base and the index wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw interrupt lines, already synchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_crit | output | 1 | Critical request |
| irq_ncrit | output | 1 | Non-critical request |
| irq_vec | output | 8 | Vector of the winning pending source |
| irq_vec_valid | output | 1 | At least one source pending |

## Verification
Two functions can act on the same status bit at the same clock edge: capture of a new request, and a software clear of that bit. The edge case is provoked by driving an edge-mode line into its active level in the very cycle that a write of 1 to its status bit is issued. The level case is provoked by clearing a level-mode bit while its line is still held active. In both cases the status register is read back afterwards, and capture must have won. Priority is judged with two latched sources under both ranking settings. A base near the top of the 8-bit range is used to expose the wrap.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int ADDR_W       = 3;
    localparam int DATA_W       = 32;
    localparam int VCFG_BASE_LO = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_ENAB = 3'd1,
        A_ROUT = 3'd2,
        A_POL  = 3'd3,
        A_TRIG = 3'd4,
        A_VCFG = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic pol_high,
    input  logic edge_mode,
    input  logic clr_req,
    output logic stat_o
);
    logic act;
    logic act_prev_q;
    logic stat_q;
    logic set_req;

    always_comb begin
        act     = pol_high ? line_in : ~line_in;
        set_req = edge_mode ? (act & ~act_prev_q) : act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_prev_q <= 1'b0;
            stat_q     <= 1'b0;
        end else begin
            act_prev_q <= act;
            stat_q     <= set_req | (stat_q & ~clr_req);
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int VEC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [N_SRC-1:0]     status,
    output logic [N_SRC-1:0]     enab_q,
    output logic [N_SRC-1:0]     rout_q,
    output logic [N_SRC-1:0]     pol_q,
    output logic [N_SRC-1:0]     trig_q,
    output logic [VEC_W-1:0]     base_q,
    output logic                 low_first_q,
    output logic [N_SRC-1:0]     clr_mask,
    output logic [DATA_W-1:0]    reg_rdata
);
    localparam int BASE_HI = VCFG_BASE_LO + VEC_W - 1;

    logic wr_stat, wr_enab, wr_rout, wr_pol, wr_trig, wr_vcfg;

    always_comb begin
        wr_stat = reg_wr && (reg_addr == A_STAT);
        wr_enab = reg_wr && (reg_addr == A_ENAB);
        wr_rout = reg_wr && (reg_addr == A_ROUT);
        wr_pol  = reg_wr && (reg_addr == A_POL);
        wr_trig = reg_wr && (reg_addr == A_TRIG);
        wr_vcfg = reg_wr && (reg_addr == A_VCFG);
        clr_mask = wr_stat ? reg_wdata[N_SRC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enab_q      <= '0;
            rout_q      <= '0;
            pol_q       <= '1;
            trig_q      <= '0;
            base_q      <= '0;
            low_first_q <= 1'b1;
        end else begin
            if (wr_enab) enab_q <= reg_wdata[N_SRC-1:0];
            if (wr_rout) rout_q <= reg_wdata[N_SRC-1:0];
            if (wr_pol)  pol_q  <= reg_wdata[N_SRC-1:0];
            if (wr_trig) trig_q <= reg_wdata[N_SRC-1:0];
            if (wr_vcfg) begin
                base_q      <= reg_wdata[BASE_HI:VCFG_BASE_LO];
                low_first_q <= reg_wdata[0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STAT: reg_rdata[N_SRC-1:0] = status;
            A_ENAB: reg_rdata[N_SRC-1:0] = enab_q;
            A_ROUT: reg_rdata[N_SRC-1:0] = rout_q;
            A_POL:  reg_rdata[N_SRC-1:0] = pol_q;
            A_TRIG: reg_rdata[N_SRC-1:0] = trig_q;
            A_VCFG: begin
                reg_rdata[BASE_HI:VCFG_BASE_LO] = base_q;
                reg_rdata[0]                    = low_first_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 32,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    input  logic             low_first,
    output logic [IDX_W-1:0] win_idx,
    output logic             any
);
    always_comb begin
        win_idx = '0;
        any     = |pend;
        if (low_first) begin
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (pend[i]) win_idx = IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (pend[i]) win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int VEC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_crit,
    output logic                 irq_ncrit,
    output logic [VEC_W-1:0]     irq_vec,
    output logic                 irq_vec_valid
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] enab_q;
    logic [N_SRC-1:0] rout_q;
    logic [N_SRC-1:0] pol_q;
    logic [N_SRC-1:0] trig_q;
    logic [N_SRC-1:0] clr_mask;
    logic [VEC_W-1:0] vec_base;
    logic             low_first;
    logic [N_SRC-1:0] pend;
    logic [IDX_W-1:0] win_idx;
    logic             any_pend;

    irq_regs #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .status      (status_q),
        .enab_q      (enab_q),
        .rout_q      (rout_q),
        .pol_q       (pol_q),
        .trig_q      (trig_q),
        .base_q      (vec_base),
        .low_first_q (low_first),
        .clr_mask    (clr_mask),
        .reg_rdata   (reg_rdata)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_src_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_in   (irq_in[g]),
            .pol_high  (pol_q[g]),
            .edge_mode (trig_q[g]),
            .clr_req   (clr_mask[g]),
            .stat_o    (status_q[g])
        );
    end

    assign pend = status_q & enab_q;

    irq_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
        .pend      (pend),
        .low_first (low_first),
        .win_idx   (win_idx),
        .any       (any_pend)
    );

    always_comb begin
        irq_crit      = |(pend & rout_q);
        irq_ncrit     = |(pend & ~rout_q);
        irq_vec_valid = any_pend;
        irq_vec       = any_pend ? (vec_base + VEC_W'(win_idx)) : '0;
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int N_SRC = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_in,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq_crit,
    input logic             irq_ncrit,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_vec_valid,
    input logic [N_SRC-1:0] status_q,
    input logic [N_SRC-1:0] enab_q,
    input logic [N_SRC-1:0] pol_q,
    input logic [N_SRC-1:0] trig_q,
    input logic [VEC_W-1:0] vec_base
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] clr_c;
    logic [N_SRC-1:0] act_c;
    logic [N_SRC-1:0] act_prev_c;
    logic [N_SRC-1:0] lvl_act_c;
    logic [N_SRC-1:0] edge_c;
    logic [VEC_W-1:0] off_c;
    logic             hit_c;

    always_comb begin
        clr_c     = (reg_wr && reg_addr == 3'd0) ? reg_wdata[N_SRC-1:0] : '0;
        act_c     = ~(irq_in ^ pol_q);
        lvl_act_c = act_c & ~trig_q;
        edge_c    = act_c & ~act_prev_c & trig_q;
        off_c     = irq_vec - vec_base;
        hit_c     = (32'(off_c) < N_SRC) && status_q[off_c[IDX_W-1:0]] && enab_q[off_c[IDX_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_prev_c <= '0;
        else        act_prev_c <= act_c;
    end

    assert_clear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status_q & $past(status_q) & ~$past(clr_c)) == '0));

    assert_level_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_act_c != '0) |=> ((status_q & $past(lvl_act_c)) == $past(lvl_act_c)));

    assert_edge_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_c != '0) |=> ((status_q & $past(edge_c)) == $past(edge_c)));

    assert_request_matches_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_crit || irq_ncrit) == irq_vec_valid));

    assert_idle_vector_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vec_valid |-> (irq_vec == '0));

    assert_vector_points_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec_valid |-> hit_c);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_in        (irq_in),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .irq_crit      (irq_crit),
    .irq_ncrit     (irq_ncrit),
    .irq_vec       (irq_vec),
    .irq_vec_valid (irq_vec_valid),
    .status_q      (status_q),
    .enab_q        (enab_q),
    .pol_q         (pol_q),
    .trig_q        (trig_q),
    .vec_base      (vec_base)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_crit, irq_ncrit, irq_vec_valid;
    logic [7:0]  irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] STAT = 3'd0, ENAB = 3'd1, ROUT = 3'd2,
                           POL = 3'd3, TRIG = 3'd4, VCFG = 3'd5;

    always #10 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_crit(irq_crit), .irq_ncrit(irq_ncrit), .irq_vec(irq_vec),
        .irq_vec_valid(irq_vec_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic outs(input string req, input logic c, input logic n, input logic v, input logic [7:0] vec);
        chk(req, "irq_crit", 32'(irq_crit), 32'(c));
        chk(req, "irq_ncrit", 32'(irq_ncrit), 32'(n));
        chk(req, "irq_vec_valid", 32'(irq_vec_valid), 32'(v));
        chk(req, "irq_vec", 32'(irq_vec), 32'(vec));
    endtask

    task automatic clean();
        irq_in = '0;
        wr(TRIG, 32'h0);
        wr(POL, 32'hFFFF_FFFF);
        wr(ENAB, 32'h0);
        wr(ROUT, 32'h0);
        wr(VCFG, 32'h1);
        wr(STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(STAT, d); chk("R1", "status", d, 32'h0);
        rd(ENAB, d); chk("R1", "enable", d, 32'h0);
        rd(ROUT, d); chk("R1", "routing", d, 32'h0);
        rd(POL, d);  chk("R1", "polarity", d, 32'hFFFF_FFFF);
        rd(TRIG, d); chk("R1", "trigger", d, 32'h0);
        rd(VCFG, d); chk("R1", "vcfg", d, 32'h1);
        outs("R1", 0, 0, 0, 8'h00);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(ENAB, 32'hA5A5_0F0F); rd(ENAB, d); chk("R2", "enable", d, 32'hA5A5_0F0F);
        wr(ROUT, 32'h1234_5678); rd(ROUT, d); chk("R2", "routing", d, 32'h1234_5678);
        wr(POL, 32'h0F0F_F0F0);  rd(POL, d);  chk("R2", "polarity", d, 32'h0F0F_F0F0);
        wr(TRIG, 32'hCAFE_0001); rd(TRIG, d); chk("R2", "trigger", d, 32'hCAFE_0001);
        wr(VCFG, 32'hFFFF_FFFF); rd(VCFG, d); chk("R2", "vcfg", d, 32'h0000_FF01);
        rd(3'd6, d); chk("R2", "addr6", d, 32'h0);
        rd(3'd7, d); chk("R2", "addr7", d, 32'h0);
        clean();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(ENAB, 32'h8);
        drive(32'h8);
        rd(STAT, d); chk("R4", "level set", d, 32'h8);
        outs("R4", 0, 1, 1, 8'd3);
        wr(STAT, 32'h8);
        rd(STAT, d); chk("R4", "clear while active ignored", d, 32'h8);
        drive(32'h0);
        rd(STAT, d); chk("R4", "latched after release", d, 32'h8);
        wr(STAT, 32'h8);
        rd(STAT, d); chk("R4", "cleared after release", d, 32'h0);
        outs("R4", 0, 0, 0, 8'h00);
        clean();
    endtask

    task automatic t_pol();
        logic [31:0] d;
        wr(POL, 32'hFFFF_FFDF);
        @(negedge clk);
        rd(STAT, d); chk("R3", "low line active", d, 32'h20);
        drive(32'h20);
        wr(STAT, 32'h20);
        rd(STAT, d); chk("R3", "high line inactive", d, 32'h0);
        clean();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(TRIG, 32'h80);
        drive(32'h80);
        drive(32'h0);
        rd(STAT, d); chk("R5", "edge held", d, 32'h80);
        wr(STAT, 32'h0);
        rd(STAT, d); chk("R5", "write zero no effect", d, 32'h80);
        drive(32'h80);
        wr(STAT, 32'h80);
        @(negedge clk);
        rd(STAT, d); chk("R5", "held line no re-set", d, 32'h0);
        clean();
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(TRIG, 32'hFFFF_FFFF);
        drive(32'h0000_0600);
        drive(32'h0);
        rd(STAT, d); chk("R6", "two edges latched", d, 32'h0000_0600);
        @(negedge clk);
        irq_in = 32'h200;
        reg_wr = 1'b1; reg_addr = STAT; reg_wdata = 32'h600;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(STAT, d); chk("R6", "set wins over clear", d, 32'h200);
        irq_in = '0;
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, d); chk("R6", "clear all", d, 32'h0);
        clean();
    endtask

    task automatic t_mask_route();
        logic [31:0] d;
        wr(TRIG, 32'hFFFF_FFFF);
        drive(32'h0001_0000);
        drive(32'h0);
        rd(STAT, d); chk("R7", "captured while masked", d, 32'h0001_0000);
        outs("R7", 0, 0, 0, 8'h00);
        wr(ENAB, 32'h0001_0000);
        outs("R7", 0, 1, 1, 8'd16);
        wr(ROUT, 32'h0001_0000);
        outs("R8", 1, 0, 1, 8'd16);
        clean();
    endtask

    task automatic t_prio();
        wr(TRIG, 32'hFFFF_FFFF);
        wr(ENAB, 32'hFFFF_FFFF);
        drive(32'h0010_0010);
        drive(32'h0);
        wr(VCFG, 32'h0000_1001);
        chk("R9", "low index wins", 32'(irq_vec), 32'h14);
        wr(VCFG, 32'h0000_1000);
        chk("R10", "high index wins", 32'(irq_vec), 32'h24);
        wr(VCFG, 32'h0000_F000);
        chk("R12", "vector wraps", 32'(irq_vec), 32'h04);
        wr(STAT, 32'hFFFF_FFFF);
        outs("R11", 0, 0, 0, 8'h00);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_level();
        t_pol();
        t_edge();
        t_collide();
        t_mask_route();
        t_prio();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule